// File: doc/BRIEF.md
# Register Stack Frame Renamer

This block translates logical general-register numbers into physical indices for a 128-entry, 64-bit register file. The file is split into a fixed global set and a stacked region that holds procedure frames. The lowest logical registers are global and are never renamed. Logical registers above the global set address the active procedure frame. They are mapped into a circular 96-entry stacked region through a rename base.

A call moves the frame by advancing the base past the caller's locals. A return restores the saved base and size. Register contents are never moved. Earlier frame descriptions are kept in an internal LIFO. An allocation that would push the total number of stacked registers in use past the region's capacity raises a spill request and holds until the request is acknowledged. The spill and fill traffic itself lies outside this block.

Top module: `regframe_renamer`

## Requirements
- R1: Logical indices 0 to 31 map to the same physical index and never flag an illegal access, whatever the frame state.
- R2: A stacked logical index r (32 or above) with r-32 below the current frame size maps to physical 32 + ((base + r - 32) mod 96), wrapping at the top of the stacked region.
- R3: A stacked logical index with r-32 at or above the current frame size drives illegal_o high and phys_o to 0.
- R4: cfm_o carries the frame size in bits [6:0] and the base in bits [14:8], with all other bits zero. After reset it reads 0 and spill_req_o, overflow_o and underflow_o are low.
- R5: An alloc strobe that fits sets the frame size to alloc_size_i, clamped to 96, and keeps the base. It is visible on the cycle after the strobe's clock edge.
- R6: A call strobe advances the base by call_locals_i modulo 96 and reduces the size by the same amount. call_locals_i is first clamped to the current size. The previous frame is saved.
- R7: A return strobe with a saved frame restores that frame's base and size exactly.
- R8: A return strobe with no saved frame raises underflow_o for one cycle and leaves cfm_o unchanged.
- R9: A call strobe while 8 frames are saved raises overflow_o for one cycle and leaves cfm_o unchanged.
- R10: An alloc that would make held caller locals plus the new size exceed 96 raises spill_req_o and leaves cfm_o unchanged. All strobes are ignored until spill_ack_i. On the ack edge the new size takes effect and spill_req_o drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lreg_i | input | 7 | Logical register index to translate |
| call_i | input | 1 | Call strobe |
| call_locals_i | input | 7 | Caller locals to step over on call |
| alloc_i | input | 1 | Frame allocation strobe |
| alloc_size_i | input | 7 | Requested frame size |
| ret_i | input | 1 | Return strobe |
| spill_ack_i | input | 1 | Acknowledge of a pending spill request |
| phys_o | output | 7 | Physical register index |
| illegal_o | output | 1 | Logical index lies outside the current frame |
| cfm_o | output | 64 | Current frame marker |
| spill_req_o | output | 1 | Spill request; an alloc is stalled |
| overflow_o | output | 1 | Call refused, saved-frame stack full |
| underflow_o | output | 1 | Return refused, no saved frame |

## Verification
The assertions assume that at most one of call_i, alloc_i and ret_i is high in any cycle. They also assume spill_ack_i is raised only while spill_req_o is high. Under these conditions, frame movement is fully defined by the strobe in that cycle. The stimulus drives every strobe as a single-cycle pulse and applies one operation per cycle. It asserts the ack only after it has seen the request. One return is issued deliberately during a pending spill to show that it is ignored.

// File: rtl/regframe_pkg.sv
package regframe_pkg;
  localparam int unsigned IDX_W = 7;

  typedef struct packed {
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] size;
    logic [IDX_W-1:0] locals;
  } frame_t;
endpackage

// File: rtl/frame_stack.sv
module frame_stack
  import regframe_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   push_i,
  input  logic   pop_i,
  input  frame_t din_i,
  output frame_t top_o,
  output logic   empty_o,
  output logic   full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  frame_t           mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign wr_ptr  = PTR_W'(cnt_q);
  assign rd_ptr  = PTR_W'(cnt_q - CNT_W'(1));
  assign top_o   = mem_q[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[wr_ptr] <= din_i;
      cnt_q         <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R9
  stack_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/reg_mapper.sv
module reg_mapper
  import regframe_pkg::*;
#(
  parameter int unsigned NUM_GLOBAL  = 32,
  parameter int unsigned NUM_STACKED = 96
) (
  input  logic [IDX_W-1:0] lreg_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W-1:0] size_i,
  output logic [IDX_W-1:0] phys_o,
  output logic             illegal_o
);
  logic [IDX_W-1:0] rel;
  logic [IDX_W:0]   sum;
  logic [IDX_W:0]   wrapped;

  assign rel     = lreg_i - IDX_W'(NUM_GLOBAL);
  assign sum     = {1'b0, base_i} + {1'b0, rel};
  assign wrapped = (sum >= (IDX_W+1)'(NUM_STACKED)) ? sum - (IDX_W+1)'(NUM_STACKED) : sum;

  always_comb begin
    phys_o    = lreg_i;
    illegal_o = 1'b0;
    if (lreg_i >= IDX_W'(NUM_GLOBAL)) begin
      if (rel >= size_i) begin
        illegal_o = 1'b1;
        phys_o    = '0;
      end else begin
        phys_o = IDX_W'(NUM_GLOBAL) + wrapped[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/regframe_renamer.sv
module regframe_renamer
  import regframe_pkg::*;
#(
  parameter int unsigned NUM_GLOBAL  = 32,
  parameter int unsigned NUM_PHYS    = 128,
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lreg_i,
  input  logic             call_i,
  input  logic [IDX_W-1:0] call_locals_i,
  input  logic             alloc_i,
  input  logic [IDX_W-1:0] alloc_size_i,
  input  logic             ret_i,
  input  logic             spill_ack_i,
  output logic [IDX_W-1:0] phys_o,
  output logic             illegal_o,
  output logic [63:0]      cfm_o,
  output logic             spill_req_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam int unsigned NUM_STACKED = NUM_PHYS - NUM_GLOBAL;
  localparam int unsigned SUM_W       = IDX_W + 1;

  logic [IDX_W-1:0] base_q, size_q, held_q, pend_q;
  logic             pending_q, ovf_q, unf_q;

  logic [IDX_W-1:0] locals_eff, alloc_eff, new_base;
  logic [SUM_W-1:0] base_sum, need;
  logic             push, pop, st_empty, st_full;
  frame_t           st_top, st_din;

  assign locals_eff = (call_locals_i > size_q) ? size_q : call_locals_i;
  assign alloc_eff  = (alloc_size_i > IDX_W'(NUM_STACKED)) ? IDX_W'(NUM_STACKED) : alloc_size_i;
  assign base_sum   = {1'b0, base_q} + {1'b0, locals_eff};
  assign new_base   = (base_sum >= SUM_W'(NUM_STACKED)) ?
                      IDX_W'(base_sum - SUM_W'(NUM_STACKED)) : IDX_W'(base_sum);
  assign need       = {1'b0, held_q} + {1'b0, alloc_eff};

  // strobe priority: return, call, alloc; all blocked during a spill
  assign pop    = !pending_q && ret_i && !st_empty;
  assign push   = !pending_q && !ret_i && call_i && !st_full;
  assign st_din = '{base: base_q, size: size_q, locals: locals_eff};

  frame_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (st_din),
    .top_o   (st_top),
    .empty_o (st_empty),
    .full_o  (st_full)
  );

  reg_mapper #(.NUM_GLOBAL(NUM_GLOBAL), .NUM_STACKED(NUM_STACKED)) u_map (
    .lreg_i    (lreg_i),
    .base_i    (base_q),
    .size_i    (size_q),
    .phys_o    (phys_o),
    .illegal_o (illegal_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      size_q    <= '0;
      held_q    <= '0;
      pend_q    <= '0;
      pending_q <= 1'b0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      if (pending_q) begin
        if (spill_ack_i) begin
          size_q    <= pend_q;
          held_q    <= IDX_W'(NUM_STACKED) - pend_q;
          pending_q <= 1'b0;
        end
      end else if (ret_i) begin
        if (st_empty) unf_q <= 1'b1;
        else begin
          base_q <= st_top.base;
          size_q <= st_top.size;
          held_q <= (held_q >= st_top.locals) ? held_q - st_top.locals : '0;
        end
      end else if (call_i) begin
        if (st_full) ovf_q <= 1'b1;
        else begin
          base_q <= new_base;
          size_q <= size_q - locals_eff;
          held_q <= held_q + locals_eff;
        end
      end else if (alloc_i) begin
        if (need > SUM_W'(NUM_STACKED)) begin
          pending_q <= 1'b1;
          pend_q    <= alloc_eff;
        end else begin
          size_q <= alloc_eff;
        end
      end
    end
  end

  assign cfm_o       = {49'd0, base_q, 1'b0, size_q};
  assign spill_req_o = pending_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  // R10
  held_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, held_q} + {1'b0, size_q}) <= SUM_W'(NUM_STACKED));
  // R10
  spill_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_req_o && !spill_ack_i |=> $stable(cfm_o) && spill_req_o);
  // R8
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> $stable(cfm_o) && !overflow_o);
  // R9
  overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $stable(cfm_o));
  // R2
  map_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lreg_i >= IDX_W'(NUM_GLOBAL)) && !illegal_o |-> phys_o >= IDX_W'(NUM_GLOBAL));
  // R3
  illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (phys_o == '0) && (lreg_i >= IDX_W'(NUM_GLOBAL)));
endmodule

// File: tb/regframe_renamer_tb_top.sv
module regframe_renamer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  lreg_i = '0, call_locals_i = '0, alloc_size_i = '0;
  logic        call_i = 0, alloc_i = 0, ret_i = 0, spill_ack_i = 0;
  logic [6:0]  phys_o;
  logic        illegal_o, spill_req_o, overflow_o, underflow_o;
  logic [63:0] cfm_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  regframe_renamer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lreg_i(lreg_i), .call_i(call_i),
    .call_locals_i(call_locals_i), .alloc_i(alloc_i), .alloc_size_i(alloc_size_i),
    .ret_i(ret_i), .spill_ack_i(spill_ack_i), .phys_o(phys_o), .illegal_o(illegal_o),
    .cfm_o(cfm_o), .spill_req_o(spill_req_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] cfm(int b, int s);
    return 64'((b << 8) | s);
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_alloc(int n);
    alloc_i = 1; alloc_size_i = 7'(n); @(negedge clk); alloc_i = 0;
  endtask
  task automatic do_call(int n);
    call_i = 1; call_locals_i = 7'(n); @(negedge clk); call_i = 0;
  endtask
  task automatic do_ret();
    ret_i = 1; @(negedge clk); ret_i = 0;
  endtask

  task automatic map(string req, int l, int exp_p, bit exp_ill);
    lreg_i = 7'(l); #1;
    chk(req, {57'd0, phys_o}, 64'(exp_p));
    chk(req, {63'd0, illegal_o}, {63'd0, exp_ill});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R4", cfm_o, 64'd0);
    chk("R4", {61'd0, spill_req_o, overflow_o, underflow_o}, 64'd0);
    map("R1", 5, 5, 0);
    map("R3", 32, 0, 1);
  endtask

  task automatic t_basic();
    do_reset();
    do_alloc(10);
    chk("R5", cfm_o, cfm(0, 10));
    map("R2", 32, 32, 0);
    map("R2", 41, 41, 0);
    map("R3", 42, 0, 1);
    do_call(4);
    chk("R6", cfm_o, cfm(4, 6));
    map("R2", 32, 36, 0);
    map("R1", 31, 31, 0);
    do_alloc(20);
    chk("R5", cfm_o, cfm(4, 20));
    map("R2", 51, 55, 0);
    do_ret();
    chk("R7", cfm_o, cfm(0, 10));
    map("R2", 35, 35, 0);
    do_call(15);
    chk("R6", cfm_o, cfm(10, 0));
    do_ret();
    chk("R7", cfm_o, cfm(0, 10));
    do_ret();
    chk("R8", {63'd0, underflow_o}, 64'd1);
    chk("R8", cfm_o, cfm(0, 10));
    @(negedge clk);
    chk("R8", {63'd0, underflow_o}, 64'd0);
  endtask

  task automatic t_wrap_spill();
    do_reset();
    do_alloc(90);
    do_call(90);
    chk("R6", cfm_o, cfm(90, 0));
    do_alloc(6);
    chk("R10", {63'd0, spill_req_o}, 64'd0);
    chk("R5", cfm_o, cfm(90, 6));
    map("R2", 37, 127, 0);
    map("R3", 38, 0, 1);
    do_call(6);
    chk("R6", cfm_o, cfm(0, 0));
    do_alloc(1);
    chk("R10", {63'd0, spill_req_o}, 64'd1);
    chk("R10", cfm_o, cfm(0, 0));
    do_ret();
    chk("R10", cfm_o, cfm(0, 0));
    chk("R10", {63'd0, spill_req_o}, 64'd1);
    spill_ack_i = 1; @(negedge clk); spill_ack_i = 0;
    chk("R10", {63'd0, spill_req_o}, 64'd0);
    chk("R10", cfm_o, cfm(0, 1));
    map("R2", 32, 32, 0);
    do_ret();
    chk("R7", cfm_o, cfm(90, 6));
    do_ret();
    chk("R7", cfm_o, cfm(0, 90));
    do_ret();
    chk("R8", {63'd0, underflow_o}, 64'd1);
  endtask

  task automatic t_overflow();
    do_reset();
    do_alloc(8);
    for (int i = 0; i < 8; i++) do_call(1);
    chk("R6", cfm_o, cfm(8, 0));
    chk("R9", {63'd0, overflow_o}, 64'd0);
    do_call(0);
    chk("R9", {63'd0, overflow_o}, 64'd1);
    chk("R9", cfm_o, cfm(8, 0));
    @(negedge clk);
    chk("R9", {63'd0, overflow_o}, 64'd0);
    do_ret();
    chk("R7", cfm_o, cfm(7, 1));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_wrap_spill();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule